// File: doc/BRIEF.md
# Forced Interrupt Request Register

This block keeps a set of software-forced, level-sensitive interrupt requests for seven priority levels. Each level has one force bit. The bits drive the request outputs directly, and each stays asserted until software drops it. Software uses two write-only command ports, one to raise a force bit and one to drop it. Each write carries an encoded source number. Because of this, an interrupt handler can retire its own forced request with a single write, without reading the force register and modifying it.

The block sits on a simple byte-wide bus. The bus has an address, a write strobe, a read strobe, write data, read data and an error response. The address map is:

| Address | Function |
| --- | --- |
| 0 | Force readback (read only) |
| 1 | Set command port |
| 2 | Clear command port |
| 3 | Unmapped |

A read of either command port ends in a bus error. The force bits can be read back at their own address.

Top module: `fi_force_top`

## Requirements
- R1: During and after a synchronous reset, `lvl_o` is all zeros and a read of address 0 returns 0x00.
- R2: A write of a byte v with 0x38 <= v <= 0x3E to the set port (address 1) sets only the request for level 63 - v. 0x38 selects level 7 and 0x3E selects level 1. The request for level L appears on `lvl_o[L-1]`, and no other bit changes.
- R3: A write of a byte v with 0x38 <= v <= 0x3E to the clear port (address 2) clears only the request for level 63 - v, using the same bit mapping as R2. No other bit changes.
- R4: A write to either command port whose low six bits fall outside 56..62 leaves `lvl_o` unchanged. This covers 0x00 to 0x37 and 0x3F.
- R5: A write to either command port with bit 7 or bit 6 set leaves `lvl_o` unchanged, even when bits 5..0 fall inside the window.
- R6: A read of address 1 or address 2 raises `err_o` in that same cycle only, with `rdata_o` at 0x00. `err_o` is never high without a read of one of these two addresses.
- R7: A command write changes `lvl_o` at the clock edge on which the write is sampled. A read of address 0 then returns `{1'b0, lvl_o}` with `err_o` low.
- R8: Writes to address 0 or address 3 leave `lvl_o` unchanged. A read of address 3 returns 0x00 with `err_o` low.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| addr_i | input | 2 | Register address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (combinational) |
| err_o | output | 1 | Bus error response for the current read |
| lvl_o | output | 7 | Forced requests, bit L-1 is level L |

## Verification
The bench probes both edges of the command window: 0x37, 0x38, 0x3E and 0x3F. An off-by-one decoder would either leave level 7 or level 1 unreachable or alias 0x3F onto a level. It writes in-window codes with bit 6 or bit 7 set, which a decoder that ignores the reserved bits would accept. It reverses the code-to-level order across all seven codes, which catches a mapping that runs ascending. It also reads the command ports and the unmapped address, to find an error that leaks onto a legal read or onto a write.

// File: rtl/fi_force_pkg.sv
package fi_force_pkg;
  // Address map of the block
  localparam int ADR_FORCE = 0;
  localparam int ADR_SET   = 1;
  localparam int ADR_CLR   = 2;

  // Command code that selects force bit k (bit k = level k+1); the
  // window runs downward in level as the code rises.
  function automatic int lvl_code(input int base, input int nlvl, input int k);
    return base + (nlvl - 1) - k;
  endfunction
endpackage

// File: rtl/fi_cmd_decode.sv
module fi_cmd_decode #(
  parameter int DATA_W   = 8,
  parameter int NUM_LVL  = 7,
  parameter int CMD_BASE = 56
) (
  input  logic               en_i,
  input  logic [DATA_W-1:0]  cmd_i,
  output logic [NUM_LVL-1:0] hit_o
);
  import fi_force_pkg::*;

  for (genvar k = 0; k < NUM_LVL; k++) begin : g_lvl
    // Full-width compare: nonzero reserved bits never match.
    localparam logic [DATA_W-1:0] CODE = DATA_W'(lvl_code(CMD_BASE, NUM_LVL, k));
    assign hit_o[k] = en_i && (cmd_i == CODE);
  end
endmodule

// File: rtl/fi_force_reg.sv
module fi_force_reg #(
  parameter int NUM_LVL = 7
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [NUM_LVL-1:0] set_i,
  input  logic [NUM_LVL-1:0] clr_i,
  output logic [NUM_LVL-1:0] q_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) q_o <= '0;
    else       q_o <= (q_o | set_i) & ~clr_i;  // clear dominates
  end
endmodule

// File: rtl/fi_bus_if.sv
module fi_bus_if #(
  parameter int ADDR_W  = 2,
  parameter int DATA_W  = 8,
  parameter int NUM_LVL = 7
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_i,
  input  logic               rd_i,
  input  logic [NUM_LVL-1:0] force_i,
  output logic               wr_set_o,
  output logic               wr_clr_o,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               err_o
);
  import fi_force_pkg::*;

  localparam logic [ADDR_W-1:0] A_FORCE = ADDR_W'(ADR_FORCE);
  localparam logic [ADDR_W-1:0] A_SET   = ADDR_W'(ADR_SET);
  localparam logic [ADDR_W-1:0] A_CLR   = ADDR_W'(ADR_CLR);

  logic sel_cmd;
  assign sel_cmd  = (addr_i == A_SET) || (addr_i == A_CLR);
  assign wr_set_o = wr_i && (addr_i == A_SET);
  assign wr_clr_o = wr_i && (addr_i == A_CLR);
  assign err_o    = rd_i && sel_cmd;

  always_comb begin
    rdata_o = '0;
    if (rd_i && addr_i == A_FORCE) rdata_o = DATA_W'(force_i);
  end
endmodule

// File: rtl/fi_force_top.sv
module fi_force_top #(
  parameter int ADDR_W   = 2,
  parameter int DATA_W   = 8,
  parameter int NUM_LVL  = 7,
  parameter int CMD_BASE = 56
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_i,
  input  logic               rd_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               err_o,
  output logic [NUM_LVL-1:0] lvl_o
);
  logic               wr_set, wr_clr;
  logic [NUM_LVL-1:0] set_vec, clr_vec;

  fi_bus_if #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_LVL(NUM_LVL)) u_bus (
    .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i), .force_i(lvl_o),
    .wr_set_o(wr_set), .wr_clr_o(wr_clr), .rdata_o(rdata_o), .err_o(err_o)
  );

  fi_cmd_decode #(.DATA_W(DATA_W), .NUM_LVL(NUM_LVL), .CMD_BASE(CMD_BASE)) u_set_dec (
    .en_i(wr_set), .cmd_i(wdata_i), .hit_o(set_vec)
  );

  fi_cmd_decode #(.DATA_W(DATA_W), .NUM_LVL(NUM_LVL), .CMD_BASE(CMD_BASE)) u_clr_dec (
    .en_i(wr_clr), .cmd_i(wdata_i), .hit_o(clr_vec)
  );

  fi_force_reg #(.NUM_LVL(NUM_LVL)) u_reg (
    .clk_i(clk_i), .rst_i(rst_i), .set_i(set_vec), .clr_i(clr_vec), .q_o(lvl_o)
  );
endmodule

// File: rtl/fi_force_chk.sv
module fi_force_chk #(
  parameter int ADDR_W  = 2,
  parameter int DATA_W  = 8,
  parameter int NUM_LVL = 7
) (
  input logic               clk_i,
  input logic               rst_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic               wr_i,
  input logic               rd_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic [DATA_W-1:0]  rdata_o,
  input logic               err_o,
  input logic [NUM_LVL-1:0] lvl_o,
  input logic [NUM_LVL-1:0] set_vec,
  input logic [NUM_LVL-1:0] clr_vec
);
  p_reset_clear_r1: assert property (@(posedge clk_i) rst_i |=> lvl_o == '0);

  p_set_onehot_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0(set_vec));

  p_set_lands_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    (set_vec != '0) |=> (lvl_o & $past(set_vec)) == $past(set_vec));

  p_clr_lands_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (clr_vec != '0) |=> (lvl_o & $past(clr_vec)) == '0);

  p_idle_hold_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (set_vec == '0 && clr_vec == '0) |=> $stable(lvl_o));

  p_reserved_nohit_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_i && wdata_i[DATA_W-1:DATA_W-2] != 2'b00) |-> (set_vec == '0 && clr_vec == '0));

  p_err_on_read_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    err_o |-> (rd_i && rdata_o == '0));

  p_err_addr_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    err_o |-> (addr_i == ADDR_W'(1) || addr_i == ADDR_W'(2)));

  p_readback_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    (rd_i && addr_i == '0) |-> (rdata_o == DATA_W'(lvl_o) && !err_o));
endmodule

bind fi_force_top fi_force_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_LVL(NUM_LVL)) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .err_o(err_o), .lvl_o(lvl_o),
  .set_vec(set_vec), .clr_vec(clr_vec)
);

// File: tb/sim_fi_force_top.sv
module sim_fi_force_top;
  localparam int PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_i = 1'b1;
  logic [1:0] addr_i = '0;
  logic       wr_i = 1'b0;
  logic       rd_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       err_o;
  logic [6:0] lvl_o;

  int vectors = 0;
  int miscompares = 0;
  logic [6:0] model = '0;

  always #(PERIOD/2) clk_i = ~clk_i;

  fi_force_top u0 (
    .clk_i(clk_i), .rst_i(rst_i), .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .err_o(err_o), .lvl_o(lvl_o)
  );

  // Returns the bit index the byte selects, or -1 when it selects none.
  function automatic int target_bit(input logic [7:0] v);
    int level;
    if (v > 8'd62 || v < 8'd56) return -1;
    level = 63 - int'(v);
    return level - 1;
  endfunction

  function automatic logic [6:0] apply(input logic [6:0] cur, input logic [1:0] a,
                                       input logic [7:0] v);
    int b;
    logic [6:0] nxt;
    b = target_bit(v);
    nxt = cur;
    if (b >= 0 && a == 2'd1) nxt[b] = 1'b1;
    if (b >= 0 && a == 2'd2) nxt[b] = 1'b0;
    return nxt;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] v, input string req);
    @(negedge clk_i);
    addr_i = a; wdata_i = v; wr_i = 1'b1;
    check({req, " no err on write"}, {31'd0, err_o}, 32'd0);
    @(negedge clk_i);
    wr_i = 1'b0;
    model = apply(model, a, v);
    check(req, {25'd0, lvl_o}, {25'd0, model});
  endtask

  task automatic rd(input logic [1:0] a, input string req);
    logic [7:0] exp_d;
    logic       exp_e;
    @(negedge clk_i);
    addr_i = a; rd_i = 1'b1;
    #1;
    exp_e = (a == 2'd1 || a == 2'd2);
    exp_d = (a == 2'd0) ? {1'b0, model} : 8'h00;
    check({req, " rdata"}, {24'd0, rdata_o}, {24'd0, exp_d});
    check({req, " err"}, {31'd0, err_o}, {31'd0, exp_e});
    @(negedge clk_i);
    rd_i = 1'b0;
    #1;
    check({req, " err one cycle"}, {31'd0, err_o}, 32'd0);
  endtask

  initial begin
    #(PERIOD * 150000);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk_i);
    check("R1 lvl during reset", {25'd0, lvl_o}, 32'd0);
    rst_i = 1'b0;
    rd(2'd0, "R1 readback after reset");

    // R2: every in-window code, checking the descending level order
    for (int c = 56; c <= 62; c++) wr(2'd1, 8'(c), "R2 set walk");
    // R3: clear them one at a time
    for (int c = 62; c >= 56; c--) wr(2'd2, 8'(c), "R3 clear walk");
    wr(2'd1, 8'h38, "R2 code 0x38 -> level 7");
    check("R2 bit 6", {31'd0, lvl_o[6]}, 32'd1);
    wr(2'd1, 8'h3E, "R2 code 0x3E -> level 1");
    check("R2 bit 0", {31'd0, lvl_o[0]}, 32'd1);
    // R4 window edges
    wr(2'd1, 8'h37, "R4 set 0x37 ignored");
    wr(2'd1, 8'h3F, "R4 set 0x3F ignored");
    wr(2'd2, 8'h37, "R4 clr 0x37 ignored");
    wr(2'd2, 8'h3F, "R4 clr 0x3F ignored");
    wr(2'd1, 8'h00, "R4 set 0x00 ignored");
    // R5 reserved bits
    wr(2'd1, 8'h7A, "R5 set with bit6 ignored");
    wr(2'd2, 8'hB8, "R5 clr with bit7 ignored");
    wr(2'd2, 8'hFE, "R5 clr with both ignored");
    // R6 error reads
    rd(2'd1, "R6 read set port");
    rd(2'd2, "R6 read clr port");
    // R7 / R8
    rd(2'd0, "R7 readback");
    wr(2'd0, 8'h3A, "R8 write readback addr ignored");
    wr(2'd3, 8'h3B, "R8 write unmapped ignored");
    rd(2'd3, "R8 read unmapped");

    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      logic [1:0] a;
      logic [7:0] v;
      a = 2'($urandom_range(0, 3));
      case ($urandom_range(0, 3))
        0, 1: v = 8'($urandom_range(56, 62));
        2:    v = {2'($urandom_range(1, 3)), 6'($urandom_range(56, 62))};
        default: v = 8'($urandom);
      endcase
      if ($urandom_range(0, 4) == 0) rd(a, "R6/R7 random read");
      else wr(a, v, "R2/R3/R4 random write");
    end

    rst_i = 1'b1;
    @(negedge clk_i);
    model = '0;
    check("R1 reset clears", {25'd0, lvl_o}, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule